// File: doc/BRIEF.md
# Read Burst Output Serializer

This block is the read side of a double-data-rate burst memory port. A read request is taken on a main-clock true edge together with a line address. The block then fetches the four-word line at that address from the storage array. After a fixed latency of one and a half main-clock cycles it sends the words out one per output half-cycle, lowest word first. Read requests may arrive on every other main-clock true edge. Bursts started that way follow each other with no gap on the output. A request on the true edge right after an accepted one is dropped.

The output is modelled as a data bus with an output-enable (`q_oe`), which also serves as the valid flag, and a first-word marker. When no read is in flight the bus presents zero with the enable low. A free-running echo clock pair follows the output clock. In the single-clock strap mode, the output half-cycles and the echo clocks come from an internal phase of the main clock. Otherwise they come from the external output-clock edge strobes `oc_true` and `oc_comp`. In this model every clock is reduced to one beat-rate clock `clk`, and each edge of `clk` is one half-cycle of the main clock.

The block is built from four state machines:

- **Phase machine:** `PH_TRUE` and `PH_COMP`, alternating on every edge.
- **Echo machine:** `ECHO_LO` and `ECHO_HI`. It moves to `ECHO_HI` on a true output strobe and to `ECHO_LO` on a complement strobe.
- **Command machine:** `CMD_IDLE` and `CMD_BLOCK`.
  - It goes from `CMD_IDLE` to `CMD_BLOCK` when it accepts a read.
  - It goes from `CMD_BLOCK` back to `CMD_IDLE` on the next main true edge, discarding any request seen there.
- **Serializer machine:** `SER_IDLE` and `SER_RUN`.
  - It goes from `SER_IDLE` to `SER_RUN` on a complement output strobe when a fetched line is waiting, and emits word 0.
  - In `SER_RUN` it stays put while emitting words 1 and 2, one per strobe.
  - It goes from `SER_RUN` back to `SER_IDLE` when it emits word 3 and releases the line.
  - In `SER_IDLE`, any strobe with no line waiting floats the bus.

Fetched lines wait in a two-entry line queue, so a new fetch never disturbs a burst that is still being shifted out.

Top module: `read_burst_serializer`

## Requirements
- R1: While `rst_n` is low, `q_oe`=0, `q_data`=0, `q_first`=0, `echo_p`=0, `echo_n`=1 and `mem_rd_en`=0.
- R2: Main-clock true edges are the first `clk` edge after reset release and every second edge after it. A `rd_req` seen on a true edge in `CMD_IDLE` raises `mem_rd_en` for exactly one beat after that edge, with `mem_rd_addr` equal to the latched `rd_addr`. A `rd_req` seen only on a complement edge is ignored.
- R3: If a read is accepted at edge k, word 0 is on `q_data` with `q_oe`=1 and `q_first`=1 after edge k+3, which is a complement output edge. After edges k, k+1 and k+2, `q_oe` stays 0 when the bus was idle.
- R4: Words leave in ascending order on consecutive output edges. Word i is `mem_rd_line[i*WORD_W +: WORD_W]` (word 0 in the low bits). `q_first` is 1 only with word 0.
- R5: A `rd_req` on the main true edge directly after an accepted read is dropped: it causes no fetch and no burst.
- R6: Reads accepted at edges k and k+4 give eight consecutive valid beats, from edge k+3 through edge k+10, with no gap.
- R7: On the output edge after the last word of a burst, if no new burst starts there, `q_oe` falls to 0 and `q_data` returns to 0.
- R8: The echo clocks run continuously, reads or no reads. `echo_p` is 1 after a true output edge and 0 after a complement output edge, and `echo_n` is always its inverse.
- R9: With `sclk_mode`=0, output beats and the echo clocks advance only on `oc_true` or `oc_comp`. While both are 0, `q_data`, `q_oe` and the echo clocks hold, and a waiting line starts on the first `oc_comp` after the strobes resume.
- R10: `sclk_mode` (1 selects single-clock mode) is a static strap and does not change while `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock; each edge is one main-clock half-cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_mode | input | 1 | Strap: 1 = output timing from the main clock, 0 = from the output strobes |
| oc_true | input | 1 | Output-clock true-edge strobe (used when sclk_mode=0) |
| oc_comp | input | 1 | Output-clock complement-edge strobe (used when sclk_mode=0) |
| rd_req | input | 1 | Read request, sampled on main true edges |
| rd_addr | input | ADDR_W | Line address of the read |
| mem_rd_en | output | 1 | Line fetch strobe to the array |
| mem_rd_addr | output | ADDR_W | Line address of the fetch |
| mem_rd_line | input | WORD_W*BURST_LEN | Fetched line, valid one beat after mem_rd_en |
| q_data | output | WORD_W | Serialized read word, zero when not driven |
| q_oe | output | 1 | Output enable, which also marks a valid word |
| q_first | output | 1 | Marks word 0 of a burst |
| echo_p | output | 1 | Echo clock following the output true edge |
| echo_n | output | 1 | Echo clock following the output complement edge |

## Verification
A phase machine that is off by one edge moves every burst by one beat, and bursts then start on a true edge. That shows on `q_first` and on the echo levels within two edges of reset release. A command machine that fails to leave or enter `CMD_BLOCK` shows as an extra or missing `mem_rd_en` in the beat after the offending edge, and as a stray burst three edges later. A wrong beat counter or a wrong queue pointer in the serializer corrupts or reorders words, or leaves `q_oe` high past word 3. This is seen within one burst, at the latest on the eighth beat of back-to-back traffic.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    typedef enum logic {
        PH_TRUE,
        PH_COMP
    } phase_e;

    typedef enum logic {
        ECHO_LO,
        ECHO_HI
    } echo_e;

    typedef enum logic {
        CMD_IDLE,
        CMD_BLOCK
    } cmd_e;

    typedef enum logic {
        SER_IDLE,
        SER_RUN
    } ser_e;

endpackage

// File: rtl/rbs_edge_gen.sv
module rbs_edge_gen
    import rbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_mode,
    input  logic oc_true,
    input  logic oc_comp,
    output logic cmd_edge,
    output logic true_stb,
    output logic comp_stb,
    output logic echo_p,
    output logic echo_n
);

    phase_e ph_q, ph_d;
    echo_e  ec_q, ec_d;

    // Next phase
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_TRUE: ph_d = PH_COMP;
            PH_COMP: ph_d = PH_TRUE;
            default: ph_d = PH_TRUE;
        endcase
    end

    // Output strobes: internal phase or external output clock
    always_comb begin
        cmd_edge = (ph_q == PH_TRUE);
        if (sclk_mode) begin
            true_stb = (ph_q == PH_TRUE);
            comp_stb = (ph_q == PH_COMP);
        end else begin
            true_stb = oc_true;
            comp_stb = oc_comp;
        end
    end

    // Next echo level
    always_comb begin
        ec_d = ec_q;
        unique case (ec_q)
            ECHO_LO: if (true_stb) ec_d = ECHO_HI;
            ECHO_HI: if (comp_stb) ec_d = ECHO_LO;
            default: ec_d = ECHO_LO;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= PH_TRUE;
            ec_q <= ECHO_LO;
        end else begin
            ph_q <= ph_d;
            ec_q <= ec_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            echo_p <= 1'b0;
            echo_n <= 1'b1;
        end else begin
            echo_p <= (ec_d == ECHO_HI);
            echo_n <= (ec_d != ECHO_HI);
        end
    end

    // R8
    echo_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        echo_p != echo_n);

    // R8
    echo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        true_stb |=> echo_p);

    // R10
    strap_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sclk_mode));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(true_stb && comp_stb));

endmodule

// File: rtl/rbs_cmd.sv
module rbs_cmd
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_edge,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              line_cap
);

    cmd_e st_q, st_d;
    logic accept;

    // Next state
    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        unique case (st_q)
            CMD_IDLE: begin
                if (cmd_edge && rd_req) begin
                    accept = 1'b1;
                    st_d   = CMD_BLOCK;
                end
            end
            CMD_BLOCK: begin
                if (cmd_edge) st_d = CMD_IDLE;
            end
            default: st_d = CMD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CMD_IDLE;
        else        st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rd_en   <= 1'b0;
            mem_rd_addr <= '0;
            line_cap    <= 1'b0;
        end else begin
            mem_rd_en <= accept;
            line_cap  <= mem_rd_en;
            if (accept) mem_rd_addr <= rd_addr;
        end
    end

    // R5
    fetch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en ##1 !mem_rd_en ##1 !mem_rd_en);

    // R2
    fetch_on_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> $past(cmd_edge && rd_req));

endmodule

// File: rtl/rbs_line_fifo.sv
module rbs_line_fifo #(
    parameter int LINE_W = 36,
    parameter int SLOTS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic              pop,
    output logic              head_valid,
    output logic [LINE_W-1:0] head_line
);

    localparam int PTR_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int FILL_W = $clog2(SLOTS + 1);
    localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(SLOTS - 1);
    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(SLOTS);

    logic [LINE_W-1:0] slot_q [SLOTS];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [FILL_W-1:0] fill;
    logic              full, do_push, do_pop;

    assign full       = (fill == FULL_CNT);
    assign head_valid = (fill != '0);
    assign head_line  = slot_q[rd_ptr];
    assign do_pop     = pop && head_valid;
    assign do_push    = push && (!full || do_pop);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slot_q[wr_ptr] <= push_line;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));

    // R4
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

endmodule

// File: rtl/rbs_serial.sv
module rbs_serial
    import rbs_pkg::*;
#(
    parameter int WORD_W    = 9,
    parameter int BURST_LEN = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        true_stb,
    input  logic                        comp_stb,
    input  logic                        head_valid,
    input  logic [WORD_W*BURST_LEN-1:0] head_line,
    output logic                        pop,
    output logic [WORD_W-1:0]           q_data,
    output logic                        q_oe,
    output logic                        q_first
);

    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_LEN - 1);

    ser_e              st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WORD_W-1:0] data_d;
    logic              oe_d, first_d, any_stb;
    logic [WORD_W-1:0] cur_word;

    assign any_stb  = true_stb || comp_stb;
    assign cur_word = head_line[int'(cnt_q)*WORD_W +: WORD_W];

    // Next state and next outputs
    always_comb begin
        st_d    = st_q;
        cnt_d   = cnt_q;
        data_d  = q_data;
        oe_d    = q_oe;
        first_d = q_first;
        pop     = 1'b0;
        unique case (st_q)
            SER_IDLE: begin
                if (any_stb) begin
                    if (comp_stb && head_valid) begin
                        data_d  = head_line[WORD_W-1:0];
                        oe_d    = 1'b1;
                        first_d = 1'b1;
                        cnt_d   = CNT_W'(1);
                        st_d    = SER_RUN;
                    end else begin
                        data_d  = '0;
                        oe_d    = 1'b0;
                        first_d = 1'b0;
                    end
                end
            end
            SER_RUN: begin
                if (any_stb) begin
                    data_d  = cur_word;
                    oe_d    = 1'b1;
                    first_d = 1'b0;
                    if (cnt_q == LAST_BEAT) begin
                        pop   = 1'b1;
                        cnt_d = '0;
                        st_d  = SER_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: st_d = SER_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SER_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_data  <= '0;
            q_oe    <= 1'b0;
            q_first <= 1'b0;
        end else begin
            q_data  <= data_d;
            q_oe    <= oe_d;
            q_first <= first_d;
        end
    end

    // R7
    float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q_oe |-> (q_data == '0));

    // R3
    first_on_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_first |-> (q_oe && $past(comp_stb)));

    // R9
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!true_stb && !comp_stb) |=> ($stable(q_data) && $stable(q_oe)));

endmodule

// File: rtl/read_burst_serializer.sv
module read_burst_serializer #(
    parameter int WORD_W     = 9,
    parameter int ADDR_W     = 10,
    parameter int BURST_LEN  = 4,
    parameter int LINE_SLOTS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sclk_mode,
    input  logic                        oc_true,
    input  logic                        oc_comp,
    input  logic                        rd_req,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic                        mem_rd_en,
    output logic [ADDR_W-1:0]           mem_rd_addr,
    input  logic [WORD_W*BURST_LEN-1:0] mem_rd_line,
    output logic [WORD_W-1:0]           q_data,
    output logic                        q_oe,
    output logic                        q_first,
    output logic                        echo_p,
    output logic                        echo_n
);

    localparam int LINE_W = WORD_W * BURST_LEN;

    logic              cmd_edge, true_stb, comp_stb;
    logic              line_cap, pop, head_valid;
    logic [LINE_W-1:0] head_line;

    rbs_edge_gen u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_mode (sclk_mode),
        .oc_true   (oc_true),
        .oc_comp   (oc_comp),
        .cmd_edge  (cmd_edge),
        .true_stb  (true_stb),
        .comp_stb  (comp_stb),
        .echo_p    (echo_p),
        .echo_n    (echo_n)
    );

    rbs_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_edge    (cmd_edge),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .line_cap    (line_cap)
    );

    rbs_line_fifo #(.LINE_W(LINE_W), .SLOTS(LINE_SLOTS)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (line_cap),
        .push_line  (mem_rd_line),
        .pop        (pop),
        .head_valid (head_valid),
        .head_line  (head_line)
    );

    rbs_serial #(.WORD_W(WORD_W), .BURST_LEN(BURST_LEN)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .true_stb   (true_stb),
        .comp_stb   (comp_stb),
        .head_valid (head_valid),
        .head_line  (head_line),
        .pop        (pop),
        .q_data     (q_data),
        .q_oe       (q_oe),
        .q_first    (q_first)
    );

endmodule

// File: tb/read_burst_serializer_tb.sv
module read_burst_serializer_tb;

    localparam int W  = 9;
    localparam int AW = 10;
    localparam int BL = 4;
    localparam int LW = W * BL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk_mode = 1'b1;
    logic          oc_true = 1'b0;
    logic          oc_comp = 1'b0;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [LW-1:0] mem_rd_line = '0;
    logic [W-1:0]  q_data;
    logic          q_oe, q_first, echo_p, echo_n;

    int edge_n = 0;
    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;
    bit oc_run = 1'b0;

    always #5 clk = ~clk;

    read_burst_serializer #(.WORD_W(W), .ADDR_W(AW), .BURST_LEN(BL), .LINE_SLOTS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_mode(sclk_mode), .oc_true(oc_true), .oc_comp(oc_comp),
        .rd_req(rd_req), .rd_addr(rd_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_line(mem_rd_line), .q_data(q_data), .q_oe(q_oe), .q_first(q_first),
        .echo_p(echo_p), .echo_n(echo_n)
    );

    function automatic logic [W-1:0] exp_word(input logic [AW-1:0] a, input int k);
        return W'(int'(a) * 3 + k * 37 + 5);
    endfunction

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        logic [LW-1:0] l;
        for (int k = 0; k < BL; k++) l[k*W +: W] = exp_word(a, k);
        return l;
    endfunction

    // Edge counter and array model (registered line read)
    initial forever begin
        @(posedge clk);
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
        if (mem_rd_en) mem_rd_line <= line_of(mem_rd_addr);
    end

    // External output-clock strobes, true on even edge indices
    initial forever begin
        @(negedge clk);
        #1;
        oc_true = oc_run && (edge_n % 2 == 0);
        oc_comp = oc_run && (edge_n % 2 == 1);
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", tag, what, act, exp, edge_n);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic beat(input string tag, input logic oe, input logic [W-1:0] d, input logic first);
        step();
        chk(tag, "q_oe", 32'(q_oe), 32'(oe));
        chk(tag, "q_data", 32'(q_data), 32'(d));
        chk(tag, "q_first", 32'(q_first), 32'(first));
    endtask

    task automatic align_true;
        @(negedge clk);
        while (edge_n % 2 != 0) @(negedge clk);
    endtask

    task automatic align_odd;
        @(negedge clk);
        while (edge_n % 2 != 1) @(negedge clk);
    endtask

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst_n = 1'b0;
        sclk_mode = mode;
        oc_run = !mode;
        rd_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "q_oe", 32'(q_oe), 0);
        chk("R1", "q_data", 32'(q_data), 0);
        chk("R1", "q_first", 32'(q_first), 0);
        chk("R1", "echo_p", 32'(echo_p), 0);
        chk("R1", "echo_n", 32'(echo_n), 1);
        chk("R1", "mem_rd_en", 32'(mem_rd_en), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_echo;
        for (int i = 0; i < 8; i++) begin
            step();
            chk("R8", "echo_p", 32'(echo_p), 32'(edge_n % 2 == 1));
            chk("R8", "echo_n", 32'(echo_n), 32'(edge_n % 2 == 0));
        end
    endtask

    task automatic t_single(input logic [AW-1:0] a);
        align_true();
        rd_req = 1'b1;
        rd_addr = a;
        beat("R3", 1'b0, '0, 1'b0);
        rd_req = 1'b0;
        chk("R2", "mem_rd_en", 32'(mem_rd_en), 1);
        chk("R2", "mem_rd_addr", 32'(mem_rd_addr), 32'(a));
        beat("R3", 1'b0, '0, 1'b0);
        chk("R2", "mem_rd_en pulse", 32'(mem_rd_en), 0);
        beat("R3", 1'b0, '0, 1'b0);
        beat("R3", 1'b1, exp_word(a, 0), 1'b1);
        beat("R4", 1'b1, exp_word(a, 1), 1'b0);
        beat("R4", 1'b1, exp_word(a, 2), 1'b0);
        beat("R4", 1'b1, exp_word(a, 3), 1'b0);
        beat("R7", 1'b0, '0, 1'b0);
        beat("R7", 1'b0, '0, 1'b0);
    endtask

    task automatic t_ignore(input logic [AW-1:0] a, input logic [AW-1:0] c);
        align_true();
        rd_req = 1'b1;
        rd_addr = a;
        beat("R5", 1'b0, '0, 1'b0);
        rd_addr = c;
        step();
        chk("R2", "mem_rd_en odd edge", 32'(mem_rd_en), 0);
        step();
        chk("R5", "mem_rd_en second", 32'(mem_rd_en), 0);
        rd_req = 1'b0;
        beat("R5", 1'b1, exp_word(a, 0), 1'b1);
        beat("R5", 1'b1, exp_word(a, 1), 1'b0);
        beat("R5", 1'b1, exp_word(a, 2), 1'b0);
        beat("R5", 1'b1, exp_word(a, 3), 1'b0);
        for (int i = 0; i < 4; i++) beat("R5", 1'b0, '0, 1'b0);
    endtask

    task automatic t_odd(input logic [AW-1:0] a);
        align_odd();
        rd_req = 1'b1;
        rd_addr = a;
        step();
        rd_req = 1'b0;
        chk("R2", "mem_rd_en odd", 32'(mem_rd_en), 0);
        for (int i = 0; i < 6; i++) beat("R2", 1'b0, '0, 1'b0);
    endtask

    task automatic t_b2b(input logic [AW-1:0] a, input logic [AW-1:0] b);
        align_true();
        rd_req = 1'b1;
        rd_addr = a;
        beat("R6", 1'b0, '0, 1'b0);
        rd_req = 1'b0;
        beat("R6", 1'b0, '0, 1'b0);
        beat("R6", 1'b0, '0, 1'b0);
        beat("R6", 1'b1, exp_word(a, 0), 1'b1);
        rd_req = 1'b1;
        rd_addr = b;
        beat("R6", 1'b1, exp_word(a, 1), 1'b0);
        rd_req = 1'b0;
        beat("R6", 1'b1, exp_word(a, 2), 1'b0);
        beat("R6", 1'b1, exp_word(a, 3), 1'b0);
        beat("R6", 1'b1, exp_word(b, 0), 1'b1);
        beat("R6", 1'b1, exp_word(b, 1), 1'b0);
        beat("R6", 1'b1, exp_word(b, 2), 1'b0);
        beat("R6", 1'b1, exp_word(b, 3), 1'b0);
        beat("R7", 1'b0, '0, 1'b0);
    endtask

    task automatic t_stall(input logic [AW-1:0] a);
        align_true();
        rd_req = 1'b1;
        rd_addr = a;
        step();
        rd_req = 1'b0;
        oc_run = 1'b0;
        for (int i = 0; i < 5; i++) begin
            beat("R9", 1'b0, '0, 1'b0);
            chk("R9", "echo_p held", 32'(echo_p), 1);
        end
        oc_run = 1'b1;
        beat("R9", 1'b0, '0, 1'b0);
        chk("R9", "echo_p", 32'(echo_p), 1);
        beat("R9", 1'b1, exp_word(a, 0), 1'b1);
        chk("R9", "echo_p", 32'(echo_p), 0);
        beat("R9", 1'b1, exp_word(a, 1), 1'b0);
        beat("R9", 1'b1, exp_word(a, 2), 1'b0);
        beat("R9", 1'b1, exp_word(a, 3), 1'b0);
        beat("R9", 1'b0, '0, 1'b0);
    endtask

    initial begin
        do_reset(1'b1);
        t_echo();
        t_single(10'h025);
        t_single(10'h3FF);
        t_ignore(10'h101, 10'h2A2);
        t_odd(10'h0F0);
        t_b2b(10'h013, 10'h014);
        t_echo();
        do_reset(1'b0);
        t_echo();
        t_single(10'h155);
        t_stall(10'h0AA);
        t_b2b(10'h3FE, 10'h000);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(200_000 * 10);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule